// File: doc/BRIEF.md
# Byte-Lane SRAM Bank Decoder

This block connects a 32-bit processor bus to a bank of four asynchronous 4K x 8 static RAM devices that together form a 16 KB memory window at base address 0xCD000000. Each device owns one byte lane of the bus word. Device n sits on data bits 8n+7..8n, so no data steering is needed. The block decodes the full bus address, and each byte enable gates the chip select of its own device. All four devices share one 12-bit word address.

A request is a single-cycle `busValid` pulse that carries an address, byte enables and a write flag. For a hit, the block runs a fixed two-cycle device access. In the first cycle, chip selects are asserted and a write strobe is pulsed if the request is a write. In the second cycle, chip selects are held and `busAck` is raised. For a miss, the bus sees nothing: no device is selected and no acknowledge is returned. All strobes are active high.

Top module: `lane_sram_decoder`

## Requirements
- R1: A request hits only when address bits 31..14 equal 0xCD000000 bits 31..14. A miss selects no device on any cycle and never raises `busAck`.
- R2: On a hit, `devAddr` carries request address bits 13..2 and stays stable through both access cycles.
- R3: During an access, `chipSel[n]` equals byte enable n of the request. Device n serves data bits 8n+7..8n.
- R4: On a read, `outEn` equals `chipSel` in both access cycles and `wrEn` stays zero. `outEn` is never asserted together with `wrEn`.
- R5: On a write, `wrEn` equals the selected lanes in the first access cycle only. `outEn` stays zero, and `chipSel` is held for one more cycle after the strobe.
- R6: `busAck` is high for exactly one cycle, the second access cycle, and only for hits.
- R7: A request sampled at clock edge k gives chip selects after edge k and `busAck` after edge k+1. All strobes and `busAck` are low after edge k+2.
- R8: `busValid` presented while an access is in progress is ignored. The lanes, strobes and address of the running access are unchanged.
- R9: A request that hits with all byte enables low starts no access. It selects nothing and raises no acknowledge.
- R10: While `rstN` is low, all strobes and `busAck` are low.
- R11: The byte-enable patterns for lane encoding are: a byte at offset b uses enable bit b; a halfword at offset 0 uses 4'b0011 and at offset 2 uses 4'b1100; a word uses 4'b1111. Data written with any of these patterns reads back correctly in its lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Single-cycle request strobe |
| busAddr | input | 32 | Request byte address |
| busByteEn | input | 4 | Per-lane byte enables, bit n for data bits 8n+7..8n |
| busWrite | input | 1 | 1 = write, 0 = read |
| chipSel | output | 4 | Per-device chip select |
| outEn | output | 4 | Per-device output enable |
| wrEn | output | 4 | Per-device write enable |
| devAddr | output | 12 | Shared device word address |
| busAck | output | 1 | Access acknowledge, hits only |

## Verification
Inputs change on the falling edge and are captured on the next rising edge, k. The bench then samples at three falling edges. After edge k it expects the selects, write strobe and address. After edge k+1 it expects the held selects, the cleared write strobe and the acknowledge. After edge k+2 it expects every output quiet. A behavioural SRAM model in the bench latches on the rising edge that ends the first access cycle, and read data is gathered in the second cycle. A byte-wide shadow store predicts read data without reference to any signal inside the design.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  typedef struct packed {
    logic load;   // capture the request
    logic selOn;  // chip selects active
    logic rdOn;   // output enables active
    logic wrOn;   // write strobe active
  } laneCtl_t;
endpackage

// File: rtl/lane_sram_dpath.sv
module lane_sram_dpath
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES = 4,
  parameter int DEV_AW = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hCD00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busByteEn,
  output logic              hitNow,
  output logic              anyLane,
  output logic [LANES-1:0]  chipSel,
  output logic [LANES-1:0]  outEn,
  output logic [LANES-1:0]  wrEn,
  output logic [DEV_AW-1:0] devAddr
);
  localparam int LANE_W = $clog2(LANES);
  localparam int OFF_W = DEV_AW + LANE_W;

  logic [DEV_AW-1:0] addrQ;
  logic [LANES-1:0]  laneQ;

  assign hitNow  = (busAddr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign anyLane = |busByteEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      laneQ <= '0;
    end else if (ctl.load) begin
      addrQ <= busAddr[OFF_W-1:LANE_W];
      laneQ <= busByteEn;
    end
  end

  assign devAddr = addrQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chipSel[g] = ctl.selOn & laneQ[g];
    assign outEn[g]   = ctl.rdOn  & laneQ[g];
    assign wrEn[g]    = ctl.wrOn  & laneQ[g];
  end

  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|wrEn) |=> !(|wrEn));
  p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|wrEn) |=> (chipSel == $past(chipSel)));
  p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !((|outEn) && (|wrEn)));
  p_oe_in_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((outEn & ~chipSel) == '0));
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((|chipSel) && $past(|chipSel)) |-> $stable(devAddr));
endmodule

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl
  import lane_sram_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     busValid,
  input  logic     busWrite,
  input  logic     hitNow,
  input  logic     anyLane,
  output laneCtl_t ctl,
  output logic     busAck
);
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD} accState_t;

  accState_t state, stateNext;
  logic      writeQ;
  logic      startAcc;

  assign startAcc = (state == ST_IDLE) && busValid && hitNow && anyLane;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (startAcc) stateNext = ST_STROBE;
      ST_STROBE: stateNext = ST_HOLD;
      ST_HOLD:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      writeQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (startAcc) writeQ <= busWrite;
    end
  end

  always_comb begin
    ctl.load  = startAcc;
    ctl.selOn = (state != ST_IDLE);
    ctl.rdOn  = (state != ST_IDLE) && !writeQ;
    ctl.wrOn  = (state == ST_STROBE) && writeQ;
  end

  assign busAck = (state == ST_HOLD);

  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);
  p_ack_after_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(ctl.selOn));
  p_quiet_after_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !ctl.selOn);
  p_miss_no_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !hitNow) |-> !ctl.load);
endmodule

// File: rtl/lane_sram_decoder.sv
module lane_sram_decoder
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES = 4,
  parameter int DEV_AW = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hCD00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busByteEn,
  input  logic              busWrite,
  output logic [LANES-1:0]  chipSel,
  output logic [LANES-1:0]  outEn,
  output logic [LANES-1:0]  wrEn,
  output logic [DEV_AW-1:0] devAddr,
  output logic              busAck
);
  laneCtl_t ctl;
  logic     hitNow;
  logic     anyLane;

  lane_sram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .hitNow(hitNow), .anyLane(anyLane), .ctl(ctl), .busAck(busAck)
  );

  lane_sram_dpath #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DEV_AW(DEV_AW), .BASE_ADDR(BASE_ADDR)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busAddr(busAddr), .busByteEn(busByteEn),
    .hitNow(hitNow), .anyLane(anyLane), .chipSel(chipSel), .outEn(outEn),
    .wrEn(wrEn), .devAddr(devAddr)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rstN |-> (chipSel == '0 && wrEn == '0 && outEn == '0 && !busAck));
endmodule

// File: tb/lane_sram_decoder_tb_top.sv
module lane_sram_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic        busWrite = 1'b0;
  logic [3:0]  chipSel, outEn, wrEn;
  logic [11:0] devAddr;
  logic        busAck;
  logic [31:0] wData = '0;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] memArr [4][4096];
  logic [7:0] shadow [int];

  always #10 clk = ~clk;

  lane_sram_decoder dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWrite(busWrite), .chipSel(chipSel),
    .outEn(outEn), .wrEn(wrEn), .devAddr(devAddr), .busAck(busAck)
  );

  // Behavioural SRAM bank: device n holds byte lane n
  always @(posedge clk) begin
    for (int n = 0; n < 4; n++)
      if (chipSel[n] && wrEn[n]) memArr[n][devAddr] <= wData[8*n +: 8];
  end

  function automatic logic [31:0] readBus();
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++)
      if (chipSel[n] && outEn[n]) v[8*n +: 8] = memArr[n][devAddr];
    return v;
  endfunction

  function automatic bit isHit(logic [31:0] a);
    return a[31:14] == 18'(32'hCD00_0000 >> 14);
  endfunction

  function automatic logic [7:0] shadowByte(logic [31:0] a, int n);
    int key = {a[13:2], 2'(n)};
    return shadow.exists(key) ? shadow[key] : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic runAccess(logic [31:0] a, logic [3:0] be, logic wr,
                           logic [31:0] wd, bit poke);
    bit go = isHit(a) && (be != 4'h0);
    logic [3:0] lanes = go ? be : 4'h0;
    logic [31:0] expRd = '0;
    logic [31:0] mask = '0;
    @(negedge clk);
    busAddr = a; busByteEn = be; busWrite = wr; busValid = 1'b1; wData = wd;
    @(negedge clk);
    // first access cycle
    if (poke && go) begin
      busAddr = a ^ 32'h0000_0FF0; busByteEn = ~be; busWrite = ~wr;
    end else busValid = 1'b0;
    chk("R1 R3 chipSel cycle1", 32'(chipSel), 32'(lanes));
    if (go) chk("R2 devAddr", 32'(devAddr), 32'(a[13:2]));
    chk("R4 outEn cycle1", 32'(outEn), wr ? 32'h0 : 32'(lanes));
    chk("R5 wrEn pulse", 32'(wrEn), wr ? 32'(lanes) : 32'h0);
    chk("R7 no ack cycle1", 32'(busAck), 32'h0);
    if (go && wr)
      for (int n = 0; n < 4; n++)
        if (be[n]) shadow[{a[13:2], 2'(n)}] = wd[8*n +: 8];
    @(negedge clk);
    busValid = 1'b0;
    // second access cycle
    chk(poke ? "R8 chipSel held" : "R5 R7 chipSel cycle2", 32'(chipSel), 32'(lanes));
    if (go) chk(poke ? "R8 devAddr held" : "R2 devAddr stable", 32'(devAddr), 32'(a[13:2]));
    chk("R5 wrEn cleared", 32'(wrEn), 32'h0);
    chk("R4 outEn cycle2", 32'(outEn), wr ? 32'h0 : 32'(lanes));
    chk(go ? "R6 ack" : "R1 R9 no ack", 32'(busAck), 32'(go));
    if (go && !wr) begin
      for (int n = 0; n < 4; n++)
        if (be[n]) begin
          expRd[8*n +: 8] = shadowByte(a, n);
          mask[8*n +: 8] = 8'hFF;
        end
      chk("R11 R3 read data lanes", readBus() & mask, expRd);
    end
    @(negedge clk);
    chk("R7 idle strobes", {20'h0, chipSel, outEn, wrEn}, 32'h0);
    chk("R7 idle ack", 32'(busAck), 32'h0);
  endtask

  function automatic logic [3:0] pickBe(int sz, logic [1:0] r);
    case (sz)
      0: return 4'b0001 << r;
      1: return r[0] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20250611));
    // R10 reset state
    #1;
    chk("R10 reset strobes", {20'h0, chipSel, outEn, wrEn}, 32'h0);
    chk("R10 reset ack", 32'(busAck), 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R10 post-reset strobes", {20'h0, chipSel, outEn, wrEn}, 32'h0);

    // directed corners
    runAccess(32'hCD00_0000, 4'b1111, 1'b1, 32'hA1B2_C3D4, 0); // R11 word write
    runAccess(32'hCD00_0000, 4'b1111, 1'b0, 32'h0, 0);         // R11 word read
    runAccess(32'hCD00_3FFC, 4'b0011, 1'b1, 32'h1122_3344, 0); // halfword offset 0
    runAccess(32'hCD00_3FFC, 4'b1100, 1'b1, 32'h5566_7788, 0); // halfword offset 2
    runAccess(32'hCD00_3FFC, 4'b1111, 1'b0, 32'h0, 0);
    runAccess(32'hCD00_0004, 4'b0100, 1'b1, 32'h00EE_0000, 0); // byte lane 2
    runAccess(32'hCD00_0004, 4'b1111, 1'b0, 32'h0, 0);
    runAccess(32'hCD00_4000, 4'b1111, 1'b1, 32'hDEAD_BEEF, 0); // R1 just above
    runAccess(32'hCCFF_FFFC, 4'b1111, 1'b0, 32'h0, 0);         // R1 just below
    runAccess(32'hCD00_0000, 4'b1111, 1'b0, 32'h0, 0);         // R1 miss left data intact
    runAccess(32'hCD00_0010, 4'b0000, 1'b1, 32'hFFFF_FFFF, 0); // R9
    runAccess(32'hCD00_0020, 4'b0110, 1'b1, 32'h0, 0);
    runAccess(32'hCD00_0008, 4'b1001, 1'b0, 32'h0, 1);         // R8 busy request ignored
    runAccess(32'hCD00_000C, 4'b1111, 1'b1, 32'hCAFE_F00D, 1); // R8 on a write
    runAccess(32'hCD00_000C, 4'b1111, 1'b0, 32'h0, 0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] a;
      logic [3:0]  be = pickBe(int'(r[1:0] % 3), r[3:2]);
      if (r[31:30] != 2'b00) a = 32'hCD00_0000 | {18'h0, 6'h0, r[9:4], 2'b00};
      else begin
        a = $urandom;
        if (isHit(a)) a[31] = ~a[31];
      end
      runAccess(a, be, r[12], $urandom, r[20:18] == 3'b000);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule